// File: doc/BRIEF.md
# Motor Drive PWM Channel with Staggered Turn-Off

This block drives one motor PWM pin. A counter clock is derived from the bus clock by a divider selectable among 1, 2, 4 and 8. A period value and a duty value shape the waveform. The pulse can sit at the start of each period, at its end, or in its middle; the middle placement uses an up/down count, so one output period spans twice the period value. With a period of 256, a 16 MHz bus clock and a divider of 1, the edge-aligned output runs at 62500 Hz.

Each turn-off (high-to-low) edge can be pushed back by 0 to 3 counter clocks. When several channels share a supply, each can then switch off at a slightly different moment. Turn-on edges are never delayed.

Software programs the block through a small write port holding three registers: control, period and duty. A separate level input enables the channel. Period, duty, alignment and delay settings are held in working copies. These copies are refreshed only when a period ends, so a new setting never cuts a pulse short in the middle.

Top module: `mpwm_chan`

## Requirements
- R1: The counter advances on a bus-clock cycle only when the low control bits [1:0] (value s) are such that the low s bits of a free-running 3-bit bus-clock count since reset are all ones. This gives a step every 1, 2, 4 or 8 bus clocks. The output changes only on such a step.
- R2: Alignment code 01 (control bits [3:2]) places the pulse at the start of each period. The output is high for the first `duty` of the `period` counter steps and low for the rest.
- R3: Alignment code 10 places the pulse at the end of each period. The output is high for the last `duty` of the `period` counter steps.
- R4: Alignment code 11 makes one output period last 2×`period` counter steps. The count runs up and then down, and the output is high for 2×`duty` steps centred on the turnaround.
- R5: A duty of 0 gives a constant low output. A duty equal to or larger than the period gives a constant high output.
- R6: A period of 0 or alignment code 00 keeps the channel idle, with the output low.
- R7: Register writes land at once in the write registers. Period, duty, alignment and delay take effect only at the step that ends a period, or at the next step while the channel is idle.
- R8: Control bits [5:4] (value d) keep the output high for d more counter steps after the pulse ends. A rising edge appears at the step that causes it, and a new pulse cancels any pending delay.
- R9: When the enable input is low at the step that ends a period, the channel stops at that step and the output goes low at once, with no turn-off delay.
- R10: After reset the output is low, the channel is idle and all registers read as zero.
- R11: An idle channel starts at the first counter step at which it is enabled with a nonzero period and a non-off alignment. The count starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 unused |
| wr_data | input | CNT_W | Write data; control uses bits [5:0] |
| chan_en | input | 1 | Channel enable level |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong counter or a wrong working copy of a setting shows up as a pulse that is too wide, too narrow or in the wrong place. This becomes visible at the pin within one output period, at most 2×`period` counter steps. A stuck hold count or a missed stop shows up as a late or missing falling edge. Because of this, the pin is compared with a behavioural model on every bus clock. Pulse widths are also counted over whole periods.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  typedef enum logic [1:0] {
    ALIGN_OFF    = 2'b00,
    ALIGN_START  = 2'b01,
    ALIGN_END    = 2'b10,
    ALIGN_CENTER = 2'b11
  } align_e;

  typedef struct packed {
    logic [1:0] dly;
    align_e     mode;
    logic [1:0] psel;
  } ctrl_t;

  localparam int unsigned CTRL_W  = $bits(ctrl_t);
  localparam int unsigned PSEL_W  = 2;
  localparam int unsigned DLY_W   = 2;
  localparam logic [1:0]  SEL_CTRL = 2'd0;
  localparam logic [1:0]  SEL_PER  = 2'd1;
  localparam logic [1:0]  SEL_DUTY = 2'd2;

endpackage

// File: rtl/mpwm_presc.sv
module mpwm_presc #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] psel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_n, mask;

  always_comb begin
    mask  = ({{(DIV_W-1){1'b0}}, 1'b1} << psel) - {{(DIV_W-1){1'b0}}, 1'b1};
    tick  = ((div_q & mask) == mask);
    div_n = div_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end
endmodule

// File: rtl/mpwm_seq.sv
module mpwm_seq
  import mpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               en,
  input  logic [CNT_W-1:0]   per_r,
  input  logic [CNT_W-1:0]   duty_r,
  input  align_e             mode_r,
  input  logic [DLY_W-1:0]   dly_r,
  output logic               act_q,
  output logic               act_n,
  output logic [CNT_W:0]     k_n,
  output logic [CNT_W-1:0]   per_n,
  output logic [CNT_W-1:0]   duty_n,
  output align_e             mode_n,
  output logic [DLY_W-1:0]   dly_n,
  output logic [CNT_W-1:0]   per_q,
  output logic               load
);
  localparam int unsigned KW = CNT_W + 1;
  localparam logic [KW-1:0] K_ONE = {{(KW-1){1'b0}}, 1'b1};

  logic [KW-1:0]    k_q, len;
  logic [CNT_W-1:0] duty_q;
  align_e           mode_q;
  logic [DLY_W-1:0] dly_q;
  logic             ovf;

  // period length in counter steps; center mode doubles it
  always_comb begin
    len  = (mode_q == ALIGN_CENTER) ? {per_q, 1'b0} : {1'b0, per_q};
    ovf  = act_q && (k_q == (len - K_ONE));
    load = tick && (!act_q || ovf);
  end

  always_comb begin
    act_n  = act_q;
    k_n    = k_q;
    per_n  = per_q;
    duty_n = duty_q;
    mode_n = mode_q;
    dly_n  = dly_q;
    if (load) begin
      act_n  = en && (per_r != '0) && (mode_r != ALIGN_OFF);
      k_n    = '0;
      per_n  = per_r;
      duty_n = duty_r;
      mode_n = mode_r;
      dly_n  = dly_r;
    end else if (tick && act_q) begin
      k_n = k_q + K_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      k_q    <= '0;
      per_q  <= '0;
      duty_q <= '0;
      mode_q <= ALIGN_OFF;
      dly_q  <= '0;
    end else begin
      act_q  <= act_n;
      k_q    <= k_n;
      per_q  <= per_n;
      duty_q <= duty_n;
      mode_q <= mode_n;
      dly_q  <= dly_n;
    end
  end
endmodule

// File: rtl/mpwm_wave.sv
module mpwm_wave
  import mpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             act,
  input  logic [CNT_W:0]   k,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] duty,
  input  align_e           mode,
  output logic             wave
);
  localparam int unsigned KW = CNT_W + 1;
  localparam logic [KW-1:0] K_ONE = {{(KW-1){1'b0}}, 1'b1};

  logic [KW-1:0] per_x, duty_x, thr, fold;
  logic          full, w;

  always_comb begin
    per_x  = {1'b0, per};
    duty_x = {1'b0, duty};
    full   = (duty_x >= per_x);
    thr    = per_x - duty_x;
    fold   = (k < per_x) ? k : ({per, 1'b0} - K_ONE - k);
    unique case (mode)
      ALIGN_START:  w = (k < duty_x);
      ALIGN_END:    w = full || (k >= thr);
      ALIGN_CENTER: w = full || (fold >= thr);
      default:      w = 1'b0;
    endcase
    wave = act && w;
  end
endmodule

// File: rtl/mpwm_dly.sv
module mpwm_dly #(
  parameter int unsigned DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             act_n,
  input  logic             wave_n,
  input  logic [DLY_W-1:0] dly_n,
  output logic             pwm_out
);
  localparam logic [DLY_W-1:0] H_ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic             out_q, out_n, wave_q, wave_qn;
  logic [DLY_W-1:0] hold_q, hold_n;

  always_comb begin
    out_n   = out_q;
    hold_n  = hold_q;
    wave_qn = wave_q;
    if (tick) begin
      wave_qn = wave_n;
      if (wave_n) begin
        out_n  = 1'b1;
        hold_n = '0;
      end else if (!act_n) begin
        out_n  = 1'b0;
        hold_n = '0;
      end else if (wave_q) begin
        out_n  = (dly_n != '0);
        hold_n = dly_n;
      end else if (hold_q != '0) begin
        hold_n = hold_q - H_ONE;
        out_n  = (hold_q > H_ONE);
      end else begin
        out_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      wave_q <= 1'b0;
      hold_q <= '0;
    end else begin
      out_q  <= out_n;
      wave_q <= wave_qn;
      hold_q <= hold_n;
    end
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
  import mpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             chan_en,
  output logic             pwm_out
);
  ctrl_t            ctrl_r, ctrl_n;
  logic [CNT_W-1:0] per_r, per_rn, duty_r, duty_rn;

  logic             tick, act_q, act_n, load, wave_n;
  logic [CNT_W:0]   k_n;
  logic [CNT_W-1:0] per_n, duty_n, per_sh;
  align_e           mode_n;
  logic [DLY_W-1:0] dly_n;

  always_comb begin
    ctrl_n  = ctrl_r;
    per_rn  = per_r;
    duty_rn = duty_r;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_CTRL: ctrl_n  = ctrl_t'(wr_data[CTRL_W-1:0]);
        SEL_PER:  per_rn  = wr_data;
        SEL_DUTY: duty_rn = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      per_r  <= '0;
      duty_r <= '0;
    end else begin
      ctrl_r <= ctrl_n;
      per_r  <= per_rn;
      duty_r <= duty_rn;
    end
  end

  mpwm_presc #(.SEL_W(PSEL_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .psel (ctrl_r.psel),
    .tick (tick)
  );

  mpwm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .en    (chan_en),
    .per_r (per_r),
    .duty_r(duty_r),
    .mode_r(ctrl_r.mode),
    .dly_r (ctrl_r.dly),
    .act_q (act_q),
    .act_n (act_n),
    .k_n   (k_n),
    .per_n (per_n),
    .duty_n(duty_n),
    .mode_n(mode_n),
    .dly_n (dly_n),
    .per_q (per_sh),
    .load  (load)
  );

  mpwm_wave #(.CNT_W(CNT_W)) u_wave (
    .act (act_n),
    .k   (k_n),
    .per (per_n),
    .duty(duty_n),
    .mode(mode_n),
    .wave(wave_n)
  );

  mpwm_dly #(.DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .act_n  (act_n),
    .wave_n (wave_n),
    .dly_n  (dly_n),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/mpwm_chan_chk.sv
module mpwm_chan_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wave_n,
  input logic             act_q,
  input logic             load,
  input logic [CNT_W-1:0] per_sh,
  input logic             pwm_out
);
  // R1
  step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_out));

  // R8
  rise_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wave_n) |=> pwm_out);

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> !pwm_out);

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !pwm_out);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(per_sh));
endmodule

bind mpwm_chan mpwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .wave_n (wave_n),
  .act_q  (act_q),
  .load   (load),
  .per_sh (per_sh),
  .pwm_out(pwm_out)
);

// File: tb/mpwm_chan_bench.sv
module mpwm_chan_bench;
  localparam int CLK_PER = 10;
  localparam int CNT_W   = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             chan_en = 1'b0;
  logic             pwm_out;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R10";

  mpwm_chan #(.CNT_W(CNT_W)) u_mpwm_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .chan_en(chan_en), .pwm_out(pwm_out)
  );

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference
  int m_div, m_act, m_k, m_per, m_duty, m_mode, m_d, m_wq, m_h, m_out;
  int r_ps, r_mode, r_d, r_per, r_duty;
  int t_mask, t_tick, t_len, t_load, t_w;

  function automatic int wave_of(int act, int k, int per, int duty, int mode);
    int f;
    if (act == 0) return 0;
    f = (k < per) ? k : (2*per - 1 - k);
    case (mode)
      1: return (k < duty) ? 1 : 0;
      2: return (duty >= per || k >= per - duty) ? 1 : 0;
      3: return (duty >= per || f >= per - duty) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_act = 0; m_k = 0; m_per = 0; m_duty = 0; m_mode = 0;
      m_d = 0; m_wq = 0; m_h = 0; m_out = 0;
      r_ps = 0; r_mode = 0; r_d = 0; r_per = 0; r_duty = 0;
    end else begin
      t_mask = (1 << r_ps) - 1;
      t_tick = ((m_div & t_mask) == t_mask) ? 1 : 0;
      m_div  = (m_div + 1) % 8;
      if (t_tick != 0) begin
        t_len  = (m_mode == 3) ? 2*m_per : m_per;
        t_load = (m_act == 0 || m_k == t_len - 1) ? 1 : 0;
        if (t_load != 0) begin
          m_act  = (chan_en && r_per != 0 && r_mode != 0) ? 1 : 0;
          m_k    = 0;
          m_per  = r_per; m_duty = r_duty; m_mode = r_mode; m_d = r_d;
        end else begin
          m_k = m_k + 1;
        end
        t_w = wave_of(m_act, m_k, m_per, m_duty, m_mode);
        if (t_w != 0)        begin m_out = 1; m_h = 0; end
        else if (m_act == 0) begin m_out = 0; m_h = 0; end
        else if (m_wq != 0)  begin m_h = m_d; m_out = (m_d != 0) ? 1 : 0; end
        else if (m_h != 0)   begin m_out = (m_h > 1) ? 1 : 0; m_h = m_h - 1; end
        else m_out = 0;
        m_wq = t_w;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin r_ps = wr_data[1:0]; r_mode = wr_data[3:2]; r_d = wr_data[5:4]; end
          2'd1: r_per  = wr_data;
          2'd2: r_duty = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) check(cur_req, int'(pwm_out), m_out);
  end

  task automatic wr(logic [1:0] sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(int ps, int mode, int d);
    wr(2'd0, ps | (mode << 2) | (d << 4));
  endtask

  task automatic measure(string req, int n, int exp);
    int c = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
    check(req, c, exp);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER*150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    settle(3);
    @(negedge clk); rst_n = 1'b1;
    // R10: output low after reset
    check("R10", int'(pwm_out), 0);
    settle(2);
    check("R10", int'(pwm_out), 0);

    // R6: period 0 keeps idle
    cur_req = "R6";
    chan_en = 1'b1;
    cfg(0, 1, 0); wr(2'd2, 3);
    settle(10);
    measure("R6", 20, 0);
    // R6: mode off keeps idle
    wr(2'd1, 5); cfg(0, 0, 0);
    settle(10);
    measure("R6", 20, 0);

    // R11 / R2: start edge aligned
    cur_req = "R11";
    wr(2'd2, 2); cfg(0, 1, 0);
    settle(12);
    cur_req = "R2";
    measure("R2", 20, 8);

    // R3: end aligned, buffered mode change
    cur_req = "R3";
    cfg(0, 2, 0);
    settle(12);
    measure("R3", 20, 8);

    // R4: center, per 4 duty 1 => 8-step period, 2 high
    cur_req = "R4";
    wr(2'd1, 4); wr(2'd2, 1); cfg(0, 3, 0);
    settle(20);
    measure("R4", 24, 6);
    wr(2'd2, 3);
    settle(20);
    measure("R4", 24, 18);

    // R5: duty extremes
    cur_req = "R5";
    wr(2'd1, 5); cfg(0, 1, 0); wr(2'd2, 0);
    settle(15);
    measure("R5", 20, 0);
    wr(2'd2, 7);
    settle(15);
    measure("R5", 20, 20);

    // R1: divider by 4, per 4 duty 1 => 16 clocks, 4 high
    cur_req = "R1";
    wr(2'd1, 4); wr(2'd2, 1); cfg(2, 1, 0);
    settle(40);
    measure("R1", 32, 8);
    cfg(3, 1, 0);
    settle(80);
    measure("R1", 64, 16);

    // R8: turn-off delay
    cur_req = "R8";
    cfg(0, 1, 2); wr(2'd1, 6); wr(2'd2, 2);
    settle(20);
    measure("R8", 24, 16);
    cfg(0, 1, 3); wr(2'd1, 8); wr(2'd2, 1);
    settle(20);
    measure("R8", 24, 12);
    // delay bridging into next pulse: per 4 duty 2 d 3 => constant high
    wr(2'd1, 4); wr(2'd2, 2);
    settle(20);
    measure("R8", 20, 20);

    // R7: buffered writes changing mid-period
    cur_req = "R7";
    cfg(0, 1, 0); wr(2'd1, 10); wr(2'd2, 3);
    settle(25);
    wr(2'd2, 7); wr(2'd1, 9);
    settle(25);
    measure("R7", 27, 21);
    wr(2'd1, 0);
    settle(25);
    measure("R7", 20, 0);

    // R9: disable at overflow ignores delay
    cur_req = "R9";
    wr(2'd1, 6); wr(2'd2, 3); cfg(0, 1, 3);
    settle(20);
    chan_en = 1'b0;
    settle(15);
    measure("R9", 20, 0);

    // R11: restart
    cur_req = "R11";
    cfg(0, 1, 2);
    chan_en = 1'b1;
    settle(15);
    measure("R11", 24, 20);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule